// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block reads a run of bytes from an 8-bit asynchronous NAND flash device. It drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines itself, and it controls the direction of the data bus. A client hands it a block number, a page number, a column and a byte count. The block turns these into a command, address and read sequence on the flash pins and returns each byte on a valid/ready stream. The last byte of the run is flagged.

The flash address is built by shifting each of the three request fields by a programmable amount and adding the results. The four bytes of that word are optionally reversed. The block then sends one to four address cycles, and the second cycle carries only a nibble. The opcodes, the cycle count, the byte order and whether a confirm command follows the address are static configuration inputs. Every pin phase is timed by a single down-counter of system clocks. The counter also provides the busy wait that stands in for polling a ready/busy pin. After reset the block first issues a reset command to the flash and waits out the busy interval. Only then does it accept requests.

Top module: `nand_read_seq`

## Requirements
- R1: While and directly after synchronous reset, the bus pins sit at their idle levels: nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle and nand_ale are 0, and nand_dq_oe is 1.
- R2: After reset the block writes cfg_reset_cmd once as a command cycle with chip enable low. It then raises chip enable and holds req_ready at 0 until the busy interval has elapsed.
- R3: Each bus write takes the write strobe low, then drives the byte, then raises the strobe. The flash takes the byte on that rising edge. A command byte has nand_cle=1 and nand_ale=0 at the rising edge, an address byte has nand_ale=1 and nand_cle=0, and the two latch enables are never high together.
- R4: An accepted request produces this order of events: chip enable low, a command write of cfg_pre_cmd, the address writes, an optional confirm, then the data reads. After the last read, chip enable returns high before req_ready rises again. No read strobe occurs before the last write of the request.
- R5: The address word is (block << cfg_blk_shift) + (page << cfg_page_shift) + (column << cfg_col_shift), taken modulo 2^32. When cfg_lsb_first is 0, its bytes are reversed (bits 7:0 swap with 31:24, and 15:8 swap with 23:16) before any cycle is sent.
- R6: With cfg_addr_cycles = N (1 to 4), exactly N address writes follow the opcode. Cycle 1 carries word bits 7:0. Cycle 2 carries {4'h0, bits 11:8}. Cycle 3 carries bits 23:16 and cycle 4 carries bits 31:24.
- R7: When cfg_post_en is 1, one command write of cfg_post_cmd follows the last address cycle. When it is 0, no write follows.
- R8: nand_dq_oe is 0 whenever nand_re_n is 0. The byte on nand_dq_in during the low phase of each read strobe is the byte delivered on out_data, in read order.
- R9: out_data and out_last hold steady while out_valid is 1 and out_ready is 0. No read strobe starts while a byte waits. out_last is 1 exactly with the final byte of the run.
- R10: A request with block >= cfg_total_blocks, page >= cfg_block_pages, count = 0, or cfg_addr_cycles outside 1 to 4 is refused. rsp_err is high for the cycle after acceptance, no bus write or read occurs, and the block stays idle.
- R11: A request is taken only when req_ready is 1. req_valid while a sequence runs is ignored, with no error and no extra bus activity.
- R12: The write and read strobes go low only while nand_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reset_cmd | input | 8 | Opcode sent at start-up |
| cfg_pre_cmd | input | 8 | Read opcode sent before the address |
| cfg_post_cmd | input | 8 | Confirm opcode sent after the address |
| cfg_post_en | input | 1 | Enables the confirm opcode |
| cfg_addr_cycles | input | 3 | Number of address cycles, 1 to 4 |
| cfg_lsb_first | input | 1 | 1 keeps the address byte order, 0 reverses it |
| cfg_blk_shift | input | 5 | Left shift applied to the block number |
| cfg_page_shift | input | 5 | Left shift applied to the page number |
| cfg_col_shift | input | 5 | Left shift applied to the column |
| cfg_total_blocks | input | BLK_W+1 | Number of valid blocks |
| cfg_block_pages | input | PG_W+1 | Number of valid pages per block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_block | input | BLK_W | Requested block |
| req_page | input | PG_W | Requested page |
| req_col | input | COL_W | Requested start column |
| req_count | input | CNT_W | Number of bytes to read |
| rsp_err | output | 1 | One-cycle pulse for a refused request |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Marks the final byte of a run |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_oe | output | 1 | 1 drives the data bus, 0 releases it |
| nand_dq_out | output | 8 | Byte driven onto the data bus |
| nand_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
The hardest states to reach are the stalls and refusals in the middle of a run. One is a byte held back by the consumer while the sequencer must keep the read strobe high. Another is a request presented while a sequence is already running. The stimulus sweeps every combination of cycle count, byte order and confirm enable with varied shift amounts. Its consumer deasserts ready on most cycles in half of the runs, so bytes pile up against the single output register. One run pushes an out-of-range request at the block in the middle of a sequence to show that it is neither accepted nor flagged. A flash model answers each read strobe with a byte computed from the strobe's index, and it logs every write-strobe rising edge together with the latch enables.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

    typedef enum logic [3:0] {
        S_INIT_GUARD,
        S_IDLE,
        S_PRE_GUARD,
        S_CE_ON,
        S_WR_LO,
        S_WR_DAT,
        S_WR_HI,
        S_WR_GAP,
        S_BUSY,
        S_RD_WAIT,
        S_RD_LO,
        S_RD_HI,
        S_RD_TURN,
        S_CE_OFF,
        S_INIT_OFF
    } seq_state_e;

    typedef enum logic [1:0] {
        W_RESET,
        W_PRE,
        W_ADDR,
        W_POST
    } wr_kind_e;

    localparam int MAX_ADDR_CYC = 4;

    typedef logic [MAX_ADDR_CYC-1:0][7:0] addr_bytes_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic [31:0] reverse_bytes(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    // Byte carried by address cycle idx; the second cycle is a nibble only.
    function automatic logic [7:0] cycle_byte(input logic [31:0] a, input logic [1:0] idx);
        logic [7:0] r;
        case (idx)
            2'd0:    r = a[7:0];
            2'd1:    r = {4'h0, a[11:8]};
            2'd2:    r = a[23:16];
            default: r = a[31:24];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nfr_addr.sv
module nfr_addr
    import nfr_pkg::*;
#(
    parameter int BLK_W = 12,
    parameter int PG_W  = 8,
    parameter int COL_W = 12
) (
    input  logic [BLK_W-1:0] block,
    input  logic [PG_W-1:0]  page,
    input  logic [COL_W-1:0] col,
    input  logic [4:0]       blk_shift,
    input  logic [4:0]       page_shift,
    input  logic [4:0]       col_shift,
    input  logic             lsb_first,
    output addr_bytes_t      cyc_bytes
);
    logic [31:0] linear;
    logic [31:0] ordered;

    always_comb begin
        linear  = (32'(block) << blk_shift) + (32'(page) << page_shift) + (32'(col) << col_shift);
        ordered = lsb_first ? linear : reverse_bytes(linear);
    end

    for (genvar i = 0; i < MAX_ADDR_CYC; i++) begin : g_cyc
        assign cyc_bytes[i] = cycle_byte(ordered, 2'(i));
    end

endmodule

// File: rtl/nfr_timer.sv
module nfr_timer #(
    parameter int W       = 8,
    parameter int RST_CNT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_CNT);
        else if (load)
            cnt <= val - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
    import nfr_pkg::*;
#(
    parameter int BLK_W       = 12,
    parameter int PG_W        = 8,
    parameter int COL_W       = 12,
    parameter int CNT_W       = 12,
    parameter int STD_DLY     = 4,
    parameter int GUARD5_DLY  = 20,
    parameter int GUARD10_DLY = 40,
    parameter int BUSY_DLY    = 20000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cfg_reset_cmd,
    input  logic [7:0]       cfg_pre_cmd,
    input  logic [7:0]       cfg_post_cmd,
    input  logic             cfg_post_en,
    input  logic [2:0]       cfg_addr_cycles,
    input  logic             cfg_lsb_first,
    input  logic [4:0]       cfg_blk_shift,
    input  logic [4:0]       cfg_page_shift,
    input  logic [4:0]       cfg_col_shift,
    input  logic [BLK_W:0]   cfg_total_blocks,
    input  logic [PG_W:0]    cfg_block_pages,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] req_block,
    input  logic [PG_W-1:0]  req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [CNT_W-1:0] req_count,
    output logic             rsp_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_dq_oe,
    output logic [7:0]       nand_dq_out,
    input  logic [7:0]       nand_dq_in
);
    localparam int MAX_D = max4(STD_DLY, GUARD5_DLY, GUARD10_DLY, BUSY_DLY);
    localparam int TMR_W = $clog2(MAX_D + 1);
    localparam logic [TMR_W-1:0] D_STD = TMR_W'(STD_DLY);
    localparam logic [TMR_W-1:0] D_G5  = TMR_W'(GUARD5_DLY);
    localparam logic [TMR_W-1:0] D_G10 = TMR_W'(GUARD10_DLY);
    localparam logic [TMR_W-1:0] D_BSY = TMR_W'(BUSY_DLY);

    seq_state_e       state, state_n;
    wr_kind_e         kind, kind_n;
    logic [1:0]       cyc_idx, cyc_idx_n;
    logic [1:0]       cyc_last;
    logic             post_en_r;
    addr_bytes_t      abytes, abytes_new;
    logic [CNT_W-1:0] remaining;
    logic [7:0]       wr_byte;
    logic             t_exp, t_load;
    logic [TMR_W-1:0] t_val;
    logic             req_bad, accept, capture;
    logic             out_valid_r, out_last_r, err_r;
    logic [7:0]       out_data_r, dq_out_r;

    nfr_addr #(.BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W)) u_addr (
        .block      (req_block),
        .page       (req_page),
        .col        (req_col),
        .blk_shift  (cfg_blk_shift),
        .page_shift (cfg_page_shift),
        .col_shift  (cfg_col_shift),
        .lsb_first  (cfg_lsb_first),
        .cyc_bytes  (abytes_new)
    );

    nfr_timer #(.W(TMR_W), .RST_CNT(GUARD10_DLY - 1)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .val     (t_val),
        .expired (t_exp)
    );

    assign req_ready = (state == S_IDLE);
    assign req_bad   = ({1'b0, req_block} >= cfg_total_blocks)
                     || ({1'b0, req_page} >= cfg_block_pages)
                     || (cfg_addr_cycles == 3'd0)
                     || (cfg_addr_cycles > 3'd4)
                     || (req_count == '0);
    assign accept    = req_ready && req_valid;
    assign capture   = (state == S_RD_LO) && t_exp;

    always_comb begin
        case (kind)
            W_RESET: wr_byte = cfg_reset_cmd;
            W_PRE:   wr_byte = cfg_pre_cmd;
            W_POST:  wr_byte = cfg_post_cmd;
            default: wr_byte = abytes[cyc_idx];
        endcase
    end

    always_comb begin
        state_n   = state;
        kind_n    = kind;
        cyc_idx_n = cyc_idx;
        t_load    = 1'b0;
        t_val     = D_STD;
        case (state)
            S_INIT_GUARD: if (t_exp) begin
                state_n = S_CE_ON; kind_n = W_RESET; t_load = 1'b1; t_val = D_G5;
            end
            S_IDLE: if (req_valid && !req_bad) begin
                state_n = S_PRE_GUARD; t_load = 1'b1; t_val = D_G10;
            end
            S_PRE_GUARD: if (t_exp) begin
                state_n = S_CE_ON; kind_n = W_PRE; t_load = 1'b1; t_val = D_G5;
            end
            S_CE_ON:  if (t_exp) begin state_n = S_WR_LO;  t_load = 1'b1; end
            S_WR_LO:  if (t_exp) begin state_n = S_WR_DAT; t_load = 1'b1; end
            S_WR_DAT: if (t_exp) begin state_n = S_WR_HI;  t_load = 1'b1; end
            S_WR_HI: if (t_exp) begin
                t_load = 1'b1;
                if (kind == W_RESET) begin
                    state_n = S_INIT_OFF; t_val = D_BSY;
                end else begin
                    state_n = S_WR_GAP;
                end
            end
            S_WR_GAP: if (t_exp) begin
                t_load = 1'b1;
                if (kind == W_PRE) begin
                    state_n = S_WR_LO; kind_n = W_ADDR; cyc_idx_n = 2'd0;
                end else if (kind == W_ADDR && cyc_idx != cyc_last) begin
                    state_n = S_WR_LO; cyc_idx_n = cyc_idx + 2'd1;
                end else if (kind == W_ADDR && post_en_r) begin
                    state_n = S_WR_LO; kind_n = W_POST;
                end else begin
                    state_n = S_BUSY; t_val = D_BSY;
                end
            end
            S_BUSY:    if (t_exp) state_n = S_RD_WAIT;
            S_RD_WAIT: if (!out_valid_r) begin state_n = S_RD_LO; t_load = 1'b1; end
            S_RD_LO:   if (t_exp) begin state_n = S_RD_HI;   t_load = 1'b1; end
            S_RD_HI:   if (t_exp) begin state_n = S_RD_TURN; t_load = 1'b1; end
            S_RD_TURN: if (t_exp) begin
                if (remaining == '0) begin
                    state_n = S_CE_OFF; t_load = 1'b1; t_val = D_G5;
                end else begin
                    state_n = S_RD_WAIT;
                end
            end
            S_CE_OFF:   if (t_exp) state_n = S_IDLE;
            S_INIT_OFF: if (t_exp) state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_INIT_GUARD;
            kind      <= W_RESET;
            cyc_idx   <= 2'd0;
            cyc_last  <= 2'd0;
            post_en_r <= 1'b0;
            abytes    <= '0;
            remaining <= '0;
            dq_out_r  <= 8'h00;
            err_r     <= 1'b0;
        end else begin
            state   <= state_n;
            kind    <= kind_n;
            cyc_idx <= cyc_idx_n;
            err_r   <= accept && req_bad;
            if (accept && !req_bad) begin
                abytes    <= abytes_new;
                cyc_last  <= cfg_addr_cycles[1:0] - 2'd1;
                post_en_r <= cfg_post_en;
                remaining <= req_count;
            end else if (capture) begin
                remaining <= remaining - CNT_W'(1);
            end
            if (state == S_WR_LO && t_exp)
                dq_out_r <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_r <= 1'b0;
            out_last_r  <= 1'b0;
            out_data_r  <= 8'h00;
        end else if (capture) begin
            out_valid_r <= 1'b1;
            out_last_r  <= (remaining == CNT_W'(1));
            out_data_r  <= nand_dq_in;
        end else if (out_valid_r && out_ready) begin
            out_valid_r <= 1'b0;
            out_last_r  <= 1'b0;
        end
    end

    // Bus pins are decoded from registered state only.
    always_comb begin
        nand_ce_n  = 1'b1;
        nand_cle   = 1'b0;
        nand_ale   = 1'b0;
        nand_we_n  = 1'b1;
        nand_re_n  = 1'b1;
        nand_dq_oe = 1'b1;
        case (state)
            S_CE_ON, S_WR_GAP, S_BUSY, S_RD_WAIT, S_RD_TURN: nand_ce_n = 1'b0;
            S_WR_LO, S_WR_DAT, S_WR_HI: begin
                nand_ce_n = 1'b0;
                nand_we_n = (state == S_WR_HI);
                nand_cle  = (kind != W_ADDR);
                nand_ale  = (kind == W_ADDR);
            end
            S_RD_LO: begin
                nand_ce_n  = 1'b0;
                nand_re_n  = 1'b0;
                nand_dq_oe = 1'b0;
            end
            S_RD_HI: begin
                nand_ce_n  = 1'b0;
                nand_dq_oe = 1'b0;
            end
            default: ;
        endcase
    end

    assign nand_dq_out = dq_out_r;
    assign out_valid   = out_valid_r;
    assign out_last    = out_last_r;
    assign out_data    = out_data_r;
    assign rsp_err     = err_r;

endmodule

// File: rtl/nfr_chk.sv
module nfr_chk (
    input logic       clk,
    input logic       rst,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       rsp_err,
    input logic       req_ready,
    input logic       req_valid
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && nand_dq_oe));

    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R8
    read_dir_chk: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    // R12
    strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    read_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !out_valid);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (nand_ce_n && req_ready));

    // R11
    err_origin_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $past(req_ready && req_valid));

endmodule

bind nand_read_seq nfr_chk u_nfr_chk (
    .clk        (clk),
    .rst        (rst),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .rsp_err    (rsp_err),
    .req_ready  (req_ready),
    .req_valid  (req_valid)
);

// File: tb/tb_nand_read_seq.sv
`timescale 1ns/1ps
module tb_nand_read_seq;
    localparam int BLK_W = 12, PG_W = 8, COL_W = 12, CNT_W = 12;
    localparam int STD = 2, G5 = 3, G10 = 4, BSY = 6;
    localparam int LOGN = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [7:0] cfg_reset_cmd = 8'hFF, cfg_pre_cmd = 8'h00, cfg_post_cmd = 8'h30;
    logic cfg_post_en = 1'b1, cfg_lsb_first = 1'b1;
    logic [2:0] cfg_addr_cycles = 3'd4;
    logic [4:0] cfg_blk_shift = 5'd20, cfg_page_shift = 5'd12, cfg_col_shift = 5'd0;
    logic [BLK_W:0] cfg_total_blocks = 13'd100;
    logic [PG_W:0] cfg_block_pages = 9'd64;
    logic req_valid = 1'b0, req_ready;
    logic [BLK_W-1:0] req_block = '0;
    logic [PG_W-1:0] req_page = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic rsp_err, out_valid, out_last, out_ready = 1'b1;
    logic [7:0] out_data;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out, nand_dq_in;

    int total = 0, bad = 0;
    int wcnt = 0, rcnt = 0, rd_idx = 0, err_cnt = 0, cyc = 0, ready_mode = 0;
    int last_re_w = 0, v_dir = 0, v_ce = 0, v_stall = 0;
    logic [9:0] wlog [LOGN];
    logic [7:0] got [LOGN];
    logic       glast [LOGN];
    logic prev_we = 1'b1, prev_re = 1'b1;

    nand_read_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W), .CNT_W(CNT_W),
                    .STD_DLY(STD), .GUARD5_DLY(G5), .GUARD10_DLY(G10), .BUSY_DLY(BSY)) dut (
        .clk(clk), .rst(rst), .cfg_reset_cmd(cfg_reset_cmd), .cfg_pre_cmd(cfg_pre_cmd),
        .cfg_post_cmd(cfg_post_cmd), .cfg_post_en(cfg_post_en), .cfg_addr_cycles(cfg_addr_cycles),
        .cfg_lsb_first(cfg_lsb_first), .cfg_blk_shift(cfg_blk_shift), .cfg_page_shift(cfg_page_shift),
        .cfg_col_shift(cfg_col_shift), .cfg_total_blocks(cfg_total_blocks),
        .cfg_block_pages(cfg_block_pages), .req_valid(req_valid), .req_ready(req_ready),
        .req_block(req_block), .req_page(req_page), .req_col(req_col), .req_count(req_count),
        .rsp_err(rsp_err), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe),
        .nand_dq_out(nand_dq_out), .nand_dq_in(nand_dq_in)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    assign nand_dq_in = pat(rd_idx);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flash model, consumer and pin monitors, all sampled at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (prev_we == 1'b0 && nand_we_n == 1'b1 && wcnt < LOGN) begin
            wlog[wcnt] = {nand_cle, nand_ale, nand_dq_out};
            wcnt++;
        end
        if (prev_re == 1'b1 && nand_re_n == 1'b0) last_re_w = wcnt;
        if (prev_re == 1'b0 && nand_re_n == 1'b1) rd_idx++;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        if (!nand_re_n && nand_dq_oe) v_dir++;
        if ((!nand_we_n || !nand_re_n) && nand_ce_n) v_ce++;
        if (!nand_re_n && out_valid) v_stall++;
        if (nand_cle && nand_ale) v_ce++;
        if (!rst && rsp_err) err_cnt++;
        out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 4) == 0);
        if (out_valid && out_ready && rcnt < LOGN) begin
            got[rcnt] = out_data;
            glast[rcnt] = out_last;
            rcnt++;
        end
    end

    function automatic logic [7:0] exp_abyte(input int blk, input int pg, input int col, input int k);
        logic [31:0] a;
        a = (32'(blk) << cfg_blk_shift) + (32'(pg) << cfg_page_shift) + (32'(col) << cfg_col_shift);
        if (!cfg_lsb_first) a = {a[7:0], a[15:8], a[23:16], a[31:24]};
        case (k)
            0: return a[7:0];
            1: return {4'h0, a[11:8]};
            2: return a[23:16];
            default: return a[31:24];
        endcase
    endfunction

    task automatic run_rd(input int blk, input int pg, input int col, input int cnt,
                          input bit exp_err, input bit poke);
        int w0, r0, i0, e0, nw, ac;
        while (!req_ready) @(negedge clk);
        w0 = wcnt; r0 = rcnt; i0 = rd_idx; e0 = err_cnt;
        req_block = BLK_W'(blk); req_page = PG_W'(pg); req_col = COL_W'(col);
        req_count = CNT_W'(cnt); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_err) begin
            chk(rsp_err == 1'b1, "R10 err pulse", rsp_err, 1);
            repeat (4 * (G10 + STD)) @(negedge clk);
            chk(wcnt == w0 && rd_idx == i0 && nand_ce_n, "R10 no bus activity", wcnt - w0, 0);
            chk(req_ready == 1'b1, "R10 stays idle", req_ready, 1);
            return;
        end
        chk(rsp_err == 1'b0, "R10 valid request not refused", rsp_err, 0);
        if (poke) begin
            req_block = BLK_W'(cfg_total_blocks); req_valid = 1'b1;
            repeat (3) begin
                @(negedge clk);
                chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
            end
            req_valid = 1'b0;
        end
        while (!(rcnt >= r0 + cnt && req_ready)) @(negedge clk);
        if (poke) chk(err_cnt == e0, "R11 ignored request flagged", err_cnt - e0, 0);
        ac = int'(cfg_addr_cycles);
        nw = 1 + ac + (cfg_post_en ? 1 : 0);
        chk(wcnt - w0 == nw, "R6 R7 write count", wcnt - w0, nw);
        chk(wlog[w0] == {2'b10, cfg_pre_cmd}, "R3 R4 pre command", wlog[w0], {2'b10, cfg_pre_cmd});
        for (int k = 0; k < ac; k++)
            chk(wlog[w0 + 1 + k] == {2'b01, exp_abyte(blk, pg, col, k)}, "R5 R6 address cycle",
                wlog[w0 + 1 + k], {2'b01, exp_abyte(blk, pg, col, k)});
        if (cfg_post_en)
            chk(wlog[w0 + 1 + ac] == {2'b10, cfg_post_cmd}, "R7 confirm command",
                wlog[w0 + 1 + ac], {2'b10, cfg_post_cmd});
        chk(last_re_w == w0 + nw, "R4 reads after writes", last_re_w, w0 + nw);
        chk(rd_idx - i0 == cnt, "R8 read strobes", rd_idx - i0, cnt);
        for (int k = 0; k < cnt; k++) begin
            chk(got[r0 + k] == pat(i0 + k), "R8 read data", got[r0 + k], pat(i0 + k));
            chk(glast[r0 + k] == (k == cnt - 1), "R9 last flag", glast[r0 + k], k == cnt - 1);
        end
        chk(nand_ce_n == 1'b1, "R4 chip enable released", nand_ce_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && nand_dq_oe,
            "R1 reset levels", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 6'b111001);
        chk(req_ready == 1'b0, "R1 not ready in reset", req_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && nand_dq_oe,
            "R1 idle after reset", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        while (wcnt == 0) begin
            chk(req_ready == 1'b0, "R2 ready before init", req_ready, 0);
            @(negedge clk);
        end
        repeat (BSY - 1) @(negedge clk);
        chk(req_ready == 1'b0, "R2 busy wait before ready", req_ready, 0);
        while (!req_ready) @(negedge clk);
        chk(wcnt == 1, "R2 one start-up write", wcnt, 1);
        chk(wlog[0] == {2'b10, cfg_reset_cmd}, "R2 reset command", wlog[0], {2'b10, cfg_reset_cmd});
        chk(nand_ce_n == 1'b1, "R2 chip enable high", nand_ce_n, 1);

        for (int ac = 1; ac <= 4; ac++)
            for (int lsb = 0; lsb < 2; lsb++)
                for (int pe = 0; pe < 2; pe++) begin
                    cfg_addr_cycles = 3'(ac);
                    cfg_lsb_first = lsb[0];
                    cfg_post_en = pe[0];
                    cfg_blk_shift = 5'(14 + 3 * ac);
                    cfg_page_shift = 5'(6 + ac + lsb);
                    cfg_col_shift = 5'(pe);
                    ready_mode = lsb ^ pe;
                    run_rd((ac * 23 + lsb * 7 + pe) % 100, (ac * 11 + lsb * 29) % 64,
                           (ac * 517 + pe * 1029) % 4096, 1 + ((ac + pe + lsb) % 4), 1'b0, 1'b0);
                end

        cfg_addr_cycles = 3'd4; cfg_lsb_first = 1'b0; cfg_post_en = 1'b1; ready_mode = 0;
        run_rd(99, 63, 4095, 2, 1'b0, 1'b0);
        run_rd(100, 0, 0, 1, 1'b1, 1'b0);
        run_rd(0, 64, 0, 1, 1'b1, 1'b0);
        run_rd(5, 5, 5, 0, 1'b1, 1'b0);
        cfg_addr_cycles = 3'd5;
        run_rd(5, 5, 5, 1, 1'b1, 1'b0);
        cfg_addr_cycles = 3'd0;
        run_rd(5, 5, 5, 1, 1'b1, 1'b0);
        cfg_addr_cycles = 3'd3; ready_mode = 1;
        run_rd(42, 17, 300, 3, 1'b0, 1'b1);

        chk(v_dir == 0, "R8 bus released during read strobe", v_dir, 0);
        chk(v_ce == 0, "R12 R3 strobe outside chip enable or latch clash", v_ce, 0);
        chk(v_stall == 0, "R9 read strobe while byte waits", v_stall, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule